// File: doc/BRIEF.md
# Frame-Decimated PI Voltage Compensator

This block turns sampled output-voltage codes from an 8-bit converter into the on-time command of a counter-based pulse-width modulator. It runs a fixed-point proportional-integral law. The error is the reference code minus the sample. The command equals the proportional gain times the error plus the integral part of an integrator. On each update, the integrator adds a fractional gain times the error. The fractional gain is a constant numerator over a power of two, realised as a constant multiply.

One sample arrives with each switching-period strobe. In fixed-frequency mode, every strobe causes an update. In pulse-skipping mode, a frame is one charge period followed by a run-time number of skipped periods. The block then updates only on the first strobe of each frame, which decimates its input by the skip count plus one. It does no arithmetic during skipped periods. The integrator is the same register in both modes, so changing mode never resets it.

The command is clamped to the modulator's counter range and held in a register. A one-cycle valid pulse marks each new command, one clock after the strobe that produced it.

Top module: `psm_pi_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd` is 0 and `cmd_valid` is 0. The integrator also starts at 0.
- R2: The error is the signed difference `ref_code - adc_code`. An update sets `cmd` to `KP*error + floor(I / 2**KI_SHIFT)`, where I is the integrator value after that same update.
- R3: Each update sets I to `I + KI_NUM*error`, saturated to the range 0 to `NUP * 2**KI_SHIFT`. I does not change between updates.
- R4: `cmd` is clamped to the range 0 to `NUP`. A negative PI sum gives 0, and a sum above `NUP` gives `NUP`.
- R5: `cmd_valid` is high for exactly the one clock after a strobe that updates. `cmd` changes only in that clock.
- R6: With `psm_en` = 0, every strobe on `tick` updates the command.
- R7: With `psm_en` = 1, an internal frame position starts at 0. A strobe at position 0 updates. A strobe at any other position does nothing: there is no valid pulse, `cmd` keeps its value and I is unchanged. Each strobe advances the position, and it returns to 0 after position `skip_n`.
- R8: Changing `psm_en` leaves I and `cmd` untouched. In fixed-frequency mode the frame position is held at 0, so the first strobe after entering pulse-skipping mode updates.
- R9: With `psm_en` = 1 and `skip_n` = 0, every strobe updates.
- R10: If `skip_n` is lowered while the frame position is greater than or equal to the new value, the next strobe does not update and returns the position to 0. The strobe after that updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the start of each switching period; `adc_code` is valid with it |
| adc_code | input | ADC_W | Sampled output-voltage code |
| ref_code | input | ADC_W | Reference code |
| psm_en | input | 1 | 1 selects pulse-skipping (decimated) operation, 0 selects fixed-frequency |
| skip_n | input | SKIP_W | Number of skipped periods per frame |
| cmd | output | CMD_W | Registered duty command, 0 to NUP |
| cmd_valid | output | 1 | One-cycle pulse marking a new command |

## Verification
The bound assertions check the per-cycle invariants on every clock: the command range, the integrator range, valid pulses only after a strobe, and the command holding between pulses. They also check that fixed-frequency strobes always update and that a strobe at a non-zero frame position never does. Only the bench scenarios can show the arithmetic values: PI sums with rounding and saturation, integrator windup and recovery, decimation counts for several skip settings, the integrator carrying across a mode change, and the frame wrap when the skip count shrinks.

// File: rtl/psm_pi_ctrl.sv
module psm_pi_ctrl #(
  parameter int ADC_W    = 8,
  parameter int SKIP_W   = 6,
  parameter int NUP      = 499,
  parameter int KP       = 50,
  parameter int KI_NUM   = 13,
  parameter int KI_SHIFT = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic [ADC_W-1:0]               adc_code,
  input  logic [ADC_W-1:0]               ref_code,
  input  logic                           psm_en,
  input  logic [SKIP_W-1:0]              skip_n,
  output logic [$clog2(NUP+1)-1:0]       cmd,
  output logic                           cmd_valid
);
  localparam int CMD_W = $clog2(NUP + 1);
  localparam int E_W   = ADC_W + 1;
  localparam int ACC_W = CMD_W + KI_SHIFT + 2;
  localparam int P_W   = E_W + $clog2(KP + 1) + 1;
  localparam int MW    = ((ACC_W > P_W) ? ACC_W : P_W) + 2;
  localparam logic signed [MW-1:0] KP_C  = MW'(KP);
  localparam logic signed [MW-1:0] KI_C  = MW'(KI_NUM);
  localparam logic signed [MW-1:0] I_MAX = MW'(NUP * (2 ** KI_SHIFT));
  localparam logic signed [MW-1:0] C_MAX = MW'(NUP);

  logic [SKIP_W-1:0]        phase;
  logic signed [MW-1:0]     integ;
  logic signed [E_W-1:0]    err;
  logic signed [MW-1:0]     err_x, integ_sum, integ_nx, pi_sum;
  logic [CMD_W-1:0]         cmd_nx;
  logic                     take;

  assign err   = $signed({1'b0, ref_code}) - $signed({1'b0, adc_code});
  assign err_x = {{(MW-E_W){err[E_W-1]}}, err};
  assign take  = tick && (!psm_en || phase == '0);

  assign integ_sum = integ + KI_C * err_x;
  assign integ_nx  = (integ_sum < 0) ? '0 : (integ_sum > I_MAX) ? I_MAX : integ_sum;
  assign pi_sum    = KP_C * err_x + (integ_nx >>> KI_SHIFT);
  assign cmd_nx    = (pi_sum < 0) ? '0 : (pi_sum > C_MAX) ? CMD_W'(NUP) : pi_sum[CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (tick) begin
      if (!psm_en || phase >= skip_n) phase <= '0;
      else                            phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ     <= '0;
      cmd       <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= take;
      if (take) begin
        integ <= integ_nx;
        cmd   <= cmd_nx;
      end
    end
  end
endmodule

// File: rtl/psm_pi_ctrl_chk.sv
module psm_pi_ctrl_chk #(
  parameter int SKIP_W = 6,
  parameter int CMD_W  = 9,
  parameter int MW     = 20,
  parameter int NUP    = 499,
  parameter int KI_SHIFT = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick,
  input logic                     psm_en,
  input logic [SKIP_W-1:0]        phase,
  input logic signed [MW-1:0]     integ,
  input logic [CMD_W-1:0]         cmd,
  input logic                     cmd_valid
);
  localparam logic signed [MW-1:0] I_MAX = MW'(NUP * (2 ** KI_SHIFT));

  a_r4_cmd_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd <= CMD_W'(NUP));
  a_r3_integ_range: assert property (@(posedge clk) disable iff (!rst_n)
    (integ >= 0) && (integ <= I_MAX));
  a_r3_integ_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(integ));
  a_r5_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(tick));
  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd));
  a_r6_pwm_updates: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !psm_en) |=> cmd_valid);
  a_r7_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psm_en && phase != '0) |=> !cmd_valid);
endmodule

bind psm_pi_ctrl psm_pi_ctrl_chk #(
  .SKIP_W(SKIP_W), .CMD_W(CMD_W), .MW(MW), .NUP(NUP), .KI_SHIFT(KI_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .psm_en(psm_en), .phase(phase),
  .integ(integ), .cmd(cmd), .cmd_valid(cmd_valid)
);

// File: tb/psm_pi_ctrl_tb.sv
module psm_pi_ctrl_tb;
  localparam int NUP = 499, KP = 50, KI = 13, SH = 7;
  localparam int IMAX = NUP * (2 ** SH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] adc_code = '0, ref_code = '0;
  logic psm_en = 1'b0;
  logic [5:0] skip_n = '0;
  logic [8:0] cmd;
  logic cmd_valid;

  int n_chk = 0, n_fail = 0;
  int m_i = 0, m_cmd = 0, m_ph = 0, n_upd = 0;

  always #4 clk = ~clk;

  psm_pi_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .adc_code(adc_code), .ref_code(ref_code),
    .psm_en(psm_en), .skip_n(skip_n), .cmd(cmd), .cmd_valid(cmd_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int e);
    int p;
    m_i = m_i + KI * e;
    if (m_i < 0) m_i = 0;
    if (m_i > IMAX) m_i = IMAX;
    p = KP * e + m_i / (2 ** SH);
    m_cmd = (p < 0) ? 0 : (p > NUP) ? NUP : p;
  endtask

  task automatic send(input int a, input int r, input string req);
    bit upd;
    upd = !psm_en || (m_ph == 0);
    @(negedge clk); adc_code = 8'(a); ref_code = 8'(r); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    if (!psm_en || m_ph >= int'(skip_n)) m_ph = 0; else m_ph++;
    if (upd) begin model_step(r - a); n_upd++; end
    chk(cmd_valid == upd, {req, " valid"}, int'(cmd_valid), int'(upd));
    chk(int'(cmd) == m_cmd, {req, " cmd"}, int'(cmd), m_cmd);
    @(negedge clk);
    chk(cmd_valid == 1'b0, {req, " R5 one-cycle valid"}, int'(cmd_valid), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cmd == 0, "R1 cmd in reset", int'(cmd), 0);
    chk(cmd_valid == 0, "R1 valid in reset", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd == 0 && cmd_valid == 0, "R1 after reset", int'(cmd), 0);
  endtask

  task automatic t_pwm;
    psm_en = 1'b0;
    send(128, 128, "R6 zero error");
    chk(cmd == 0, "R2 zero error gives 0", int'(cmd), 0);
    send(125, 128, "R2 small positive");
    send(130, 128, "R2 small negative");
    send(128, 130, "R2 error two");
    send(127, 128, "R6 error one");
  endtask

  task automatic t_windup;
    for (int k = 0; k < 45; k++) send(0, 255, "R3 windup");
    chk(int'(cmd) == NUP, "R4 high clamp", int'(cmd), NUP);
    send(100, 100, "R3 saturated integrator");
    chk(int'(cmd) == NUP, "R3 integ ceiling", int'(cmd), NUP);
    send(255, 0, "R4 low clamp");
    chk(cmd == 0, "R4 low clamp", int'(cmd), 0);
    for (int k = 0; k < 25; k++) send(255, 0, "R3 drain");
    send(9, 9, "R3 integ floor");
    chk(cmd == 0, "R3 integ floor", int'(cmd), 0);
    send(9, 10, "R2 fresh integrator");
    chk(cmd == 50, "R2 kp*1 plus 13/128", int'(cmd), 50);
  endtask

  task automatic t_psm;
    int u0;
    psm_en = 1'b1; skip_n = 6'd3; m_ph = 0;
    u0 = n_upd;
    for (int k = 0; k < 8; k++) send(120 + k, 128, "R7 decimation");
    chk(n_upd - u0 == 2, "R7 two updates in eight ticks", n_upd - u0, 2);
  endtask

  task automatic t_mode;
    psm_en = 1'b0;
    for (int k = 0; k < 4; k++) send(100, 110, "R8 build integ");
    psm_en = 1'b1; skip_n = 6'd2;
    send(110, 110, "R8 enter psm");
    chk(int'(cmd) == m_i / (2 ** SH), "R8 integ kept", int'(cmd), m_i / (2 ** SH));
    send(90, 110, "R8 skipped");
    psm_en = 1'b0;
    send(110, 110, "R8 back to pwm");
    chk(int'(cmd) == m_i / (2 ** SH), "R8 integ kept pwm", int'(cmd), m_i / (2 ** SH));
  endtask

  task automatic t_skip0;
    psm_en = 1'b1; skip_n = 6'd0;
    for (int k = 0; k < 4; k++) send(108 + k, 110, "R9 skip zero every tick");
  endtask

  task automatic t_shrink;
    psm_en = 1'b0; send(110, 110, "R10 align");
    psm_en = 1'b1; skip_n = 6'd5;
    for (int k = 0; k < 4; k++) send(105, 110, "R10 long frame");
    skip_n = 6'd1;
    send(100, 110, "R10 wrap tick");
    chk(cmd_valid == 0, "R10 wrap no valid", int'(cmd_valid), 0);
    send(104, 110, "R10 new frame");
    send(104, 110, "R10 skip in short frame");
  endtask

  initial begin
    t_reset();
    t_pwm();
    t_windup();
    t_psm();
    t_mode();
    t_skip0();
    t_shrink();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule